// File: doc/BRIEF.md
# Three-Stage Escalating Watchdog

This block guards one processor core with a watchdog that escalates over three periods of equal length. The first expiry raises a maskable interrupt. A second expiry with no service in between raises a non-maskable interrupt. A third expiry issues a one-cycle request for a chip-wide soft reset. Each period is timed by a decrementer. The decrementer is advanced by a free-running prescaler. On every reload it is loaded with the programmed length shifted up into its most significant bits, and its low bits are loaded as zero.

Software writes a two-bit mode and the length through one configuration write strobe. Mode 0 switches the unit off. Mode 1 stops after the interrupt stage, mode 2 stops after the non-maskable stage, and mode 3 runs all three stages. A separate poke strobe restarts the current period and returns the unit to its first stage. The live decrementer value and the current stage can be read on dedicated outputs at any time.

Top module: `stage_wdog`

## Requirements
- R1: Each reload places the length in the upper LEN_W bits of the decrementer and zeros in the lower PAD_W bits. With the bench configuration, length L reads back as L*4.
- R2: While running, the decrementer steps down by one once every 2^PRE_LOG2 clocks. It expires on the interval after it reads zero, so one period lasts (count+1) intervals.
- R3: The first expiry sets irq_o, moves stage_o to 1 and reloads the decrementer.
- R4: A second expiry with no intervening poke sets nmi_o and moves stage_o to 2.
- R5: In mode 3, a third expiry moves stage_o to 3 and pulses rst_req_o high for exactly one cycle.
- R6: Writing mode 0 disables the unit at once. stage_o goes to 0, irq_o and nmi_o go low, and the count holds the new length's reload value, even when pokes arrive.
- R7: A poke reloads the decrementer from the current length, returns stage_o to 0 and drops irq_o and nmi_o.
- R8: stage_o encodes the live stage: 0 is armed, 1 is interrupt raised, 2 is NMI raised, 3 is reset issued.
- R9: In modes 1 and 2, the unit stops at stage 1 or stage 2 respectively. The count then reads zero and no later stage is reached.
- R10: irq_o and nmi_o are levels. Once raised, they stay high until a poke or a disable.
- R11: A length or mode written while the unit runs leaves the current period untouched. The new length is used from the next reload onward.
- R12: A length of zero makes every period last exactly one prescaler interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Mode written with cfg_we (0 off, 1..3 last stage) |
| cfg_len | input | LEN_W | Period length written with cfg_we |
| poke | input | 1 | Service strobe: restart period, back to first stage |
| count_o | output | LEN_W+PAD_W | Live decrementer value |
| stage_o | output | 2 | Current stage |
| irq_o | output | 1 | Maskable interrupt level |
| nmi_o | output | 1 | Non-maskable interrupt level |
| rst_req_o | output | 1 | One-cycle soft-reset request |

## Verification
A wrong prescaler phase or a decrementer that is off by one shows up within one prescaler interval as a count_o value that differs from the arithmetic countdown. It also moves every later expiry to the wrong cycle. A sequencer stuck in the wrong stage shows at once on stage_o. It shows no later than the next expiry on irq_o, nmi_o or rst_req_o: an extra reset pulse, one that is missing, or a halt that never happens in modes 1 and 2. The bench sweeps every mode against every length of a narrow configuration and compares all outputs on every cycle. This places each such fault at the exact cycle where it first appears.

// File: rtl/stwd_pkg.sv
package stwd_pkg;

    typedef enum logic [1:0] {
        STG_ARMED = 2'd0,
        STG_IRQ   = 2'd1,
        STG_NMI   = 2'd2,
        STG_RESET = 2'd3
    } stage_e;

    localparam logic [1:0] MODE_OFF = 2'd0;

    // True when the stage after s is the last one the mode allows
    function automatic logic is_last_stage(input stage_e s, input logic [1:0] mode);
        logic [2:0] nxt;
        nxt = {1'b0, s} + 3'd1;
        return nxt == {1'b0, mode};
    endfunction

endpackage

// File: rtl/stwd_prescale.sv
module stwd_prescale #(
    parameter int PRE_LOG2 = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic tick
);
    logic [PRE_LOG2-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            pre_q <= '0;
        else if (run)
            pre_q <= pre_q + 1'b1;
    end

    assign tick = run && (&pre_q);
endmodule

// File: rtl/stwd_count.sv
module stwd_count #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             hold_zero,
    output logic [CNT_W-1:0] count,
    output logic             zero
);
    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (tick) begin
            if (zero)
                count <= hold_zero ? '0 : reload_val;
            else
                count <= count - 1'b1;
        end
    end

    assign zero = (count == '0);
endmodule

// File: rtl/stwd_seq.sv
module stwd_seq
    import stwd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   restart,
    input  logic   expire,
    output stage_e stage,
    output logic   rst_pulse
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stage     <= STG_ARMED;
            rst_pulse <= 1'b0;
        end else begin
            rst_pulse <= !restart && expire && (stage == STG_NMI);
            if (restart)
                stage <= STG_ARMED;
            else if (expire)
                stage <= stage_e'(stage + 2'd1);
        end
    end
endmodule

// File: rtl/stage_wdog.sv
module stage_wdog
    import stwd_pkg::*;
#(
    parameter int LEN_W    = 16,
    parameter int PAD_W    = 8,
    parameter int PRE_LOG2 = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_we,
    input  logic [1:0]             cfg_mode,
    input  logic [LEN_W-1:0]       cfg_len,
    input  logic                   poke,
    output logic [LEN_W+PAD_W-1:0] count_o,
    output logic [1:0]             stage_o,
    output logic                   irq_o,
    output logic                   nmi_o,
    output logic                   rst_req_o
);
    localparam int CNT_W = LEN_W + PAD_W;

    logic [1:0]       mode_q;
    logic [LEN_W-1:0] len_q;
    logic             idle;
    logic             cfg_restart;
    logic             restart;
    logic [CNT_W-1:0] restart_val;
    logic [CNT_W-1:0] reload_val;
    logic             run;
    logic             pre_tick;
    logic             cnt_zero;
    logic             expire;
    logic             hold_zero;
    stage_e           stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_OFF;
            len_q  <= '0;
        end else if (cfg_we) begin
            mode_q <= cfg_mode;
            len_q  <= cfg_len;
        end
    end

    assign idle        = (mode_q == MODE_OFF);
    // Enabling from off or switching off loads the written length at once
    assign cfg_restart = cfg_we && (idle || cfg_mode == MODE_OFF);
    assign restart     = cfg_restart || poke;
    assign reload_val  = {len_q, {PAD_W{1'b0}}};
    assign restart_val = cfg_restart ? {cfg_len, {PAD_W{1'b0}}} : reload_val;
    assign run         = !idle && (stage < mode_q);
    assign expire      = pre_tick && cnt_zero;
    assign hold_zero   = is_last_stage(stage, mode_q);

    stwd_prescale #(.PRE_LOG2(PRE_LOG2)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .clr  (restart),
        .run  (run),
        .tick (pre_tick)
    );

    stwd_count #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load       (restart),
        .load_val   (restart_val),
        .tick       (pre_tick),
        .reload_val (reload_val),
        .hold_zero  (hold_zero),
        .count      (count_o),
        .zero       (cnt_zero)
    );

    stwd_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .expire    (expire),
        .stage     (stage),
        .rst_pulse (rst_req_o)
    );

    assign stage_o = stage;
    assign irq_o   = (stage != STG_ARMED);
    assign nmi_o   = (stage == STG_NMI) || (stage == STG_RESET);
endmodule

// File: rtl/stage_wdog_chk.sv
module stage_wdog_chk #(
    parameter int LEN_W = 16,
    parameter int PAD_W = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   poke,
    input logic                   cfg_we,
    input logic [LEN_W+PAD_W-1:0] count_o,
    input logic [1:0]             stage_o,
    input logic                   irq_o,
    input logic                   nmi_o,
    input logic                   rst_req_o,
    input logic [1:0]             mode_q,
    input logic [LEN_W-1:0]       len_q,
    input logic                   tick,
    input logic                   zero,
    input logic                   restart
);
    p_reload_shape_r1: assert property (@(posedge clk) disable iff (rst)
        (poke && !cfg_we && mode_q != 2'd0) |=> (count_o == {$past(len_q), {PAD_W{1'b0}}}));

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && !zero && !restart) |=> (count_o == $past(count_o) - 1'b1));

    p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !restart) |=> $stable(count_o));

    p_first_expiry_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && zero && stage_o == 2'd0 && !restart) |=> (irq_o && stage_o == 2'd1));

    p_second_expiry_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && zero && stage_o == 2'd1 && !restart) |=> (nmi_o && stage_o == 2'd2));

    p_pulse_width_r5: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |=> !rst_req_o);

    p_pulse_stage_r5: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |-> (stage_o == 2'd3 && nmi_o));

    p_off_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'd0) |-> (!irq_o && !nmi_o && stage_o == 2'd0));

    p_poke_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (poke && !cfg_we) |=> (stage_o == 2'd0 && !irq_o && !nmi_o));

    p_irq_level_r10: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !restart) |=> irq_o);

    p_nmi_level_r10: assert property (@(posedge clk) disable iff (rst)
        (nmi_o && !restart) |=> nmi_o);
endmodule

bind stage_wdog stage_wdog_chk #(
    .LEN_W (LEN_W),
    .PAD_W (PAD_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .poke      (poke),
    .cfg_we    (cfg_we),
    .count_o   (count_o),
    .stage_o   (stage_o),
    .irq_o     (irq_o),
    .nmi_o     (nmi_o),
    .rst_req_o (rst_req_o),
    .mode_q    (mode_q),
    .len_q     (len_q),
    .tick      (pre_tick),
    .zero      (cnt_zero),
    .restart   (restart)
);

// File: tb/stage_wdog_test.sv
module stage_wdog_test;
    localparam int LEN_W = 4;
    localparam int PAD_W = 2;
    localparam int PRE_LOG2 = 2;
    localparam int DIV = 1 << PRE_LOG2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_we = 1'b0;
    logic [1:0]       cfg_mode = 2'd0;
    logic [LEN_W-1:0] cfg_len = '0;
    logic             poke = 1'b0;
    logic [LEN_W+PAD_W-1:0] count_o;
    logic [1:0]       stage_o;
    logic             irq_o;
    logic             nmi_o;
    logic             rst_req_o;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    stage_wdog #(.LEN_W(LEN_W), .PAD_W(PAD_W), .PRE_LOG2(PRE_LOG2)) uut (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_mode  (cfg_mode),
        .cfg_len   (cfg_len),
        .poke      (poke),
        .count_o   (count_o),
        .stage_o   (stage_o),
        .irq_o     (irq_o),
        .nmi_o     (nmi_o),
        .rst_req_o (rst_req_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after the write took effect
    task automatic cfg_write(input int m, input int l);
        cfg_we = 1'b1;
        cfg_mode = 2'(m);
        cfg_len = LEN_W'(l);
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_poke();
        poke = 1'b1;
        @(posedge clk);
        @(negedge clk);
        poke = 1'b0;
    endtask

    task automatic chk_state(input string tag, input int c, input int s, input int i, input int n);
        chk({tag, " count"}, int'(count_o), c);
        chk({tag, " stage"}, int'(stage_o), s);
        chk({tag, " irq"}, int'(irq_o), i);
        chk({tag, " nmi"}, int'(nmi_o), n);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // Reset state (R8)
        chk_state("R8 reset", 0, 0, 0, 0);
        chk("R5 reset pulse", int'(rst_req_o), 0);

        // Sweep of every mode against every length: R1 R2 R3 R4 R5 R8 R9 R10 R12
        for (int m = 1; m <= 3; m++) begin
            for (int l = 0; l < (1 << LEN_W); l++) begin
                int c;
                int p;
                cfg_write(0, 0);
                cfg_write(m, l);
                c = l << PAD_W;
                p = DIV * (c + 1);
                for (int n = 0; n <= 3 * p + 4; n++) begin
                    int e;
                    int ec;
                    string ctag;
                    e = n / p;
                    if (e > m) e = m;
                    ec = (e == m) ? 0 : c - (n - e * p) / DIV;
                    if (n == 0) ctag = "R1 reload";
                    else if (l == 0) ctag = "R12 zero length";
                    else if (e == m && m < 3) ctag = "R9 halt";
                    else ctag = "R2 countdown";
                    chk(ctag, int'(count_o), ec);
                    chk((e == m && m < 3) ? "R9 stage" : "R8 stage", int'(stage_o), e);
                    chk((n > p) ? "R10 irq level" : "R3 irq", int'(irq_o), (e >= 1) ? 1 : 0);
                    chk((n > 2 * p) ? "R10 nmi level" : "R4 nmi", int'(nmi_o), (e >= 2) ? 1 : 0);
                    chk("R5 reset pulse", int'(rst_req_o), (m == 3 && n == 3 * p) ? 1 : 0);
                    @(negedge clk);
                end
            end
        end

        // R7: poke from stage 1 and from stage 2
        cfg_write(0, 0);
        cfg_write(3, 3);
        repeat (80) @(negedge clk);
        chk_state("R10 before poke", 12 - (80 - 52) / DIV, 1, 1, 0);
        do_poke();
        chk_state("R7 poke stage1", 12, 0, 0, 0);
        repeat (110) @(negedge clk);
        chk_state("R4 stage2", 12 - (110 - 104) / DIV, 2, 1, 1);
        do_poke();
        chk_state("R7 poke stage2", 12, 0, 0, 0);

        // R7 and R9: poke out of a mode 1 halt, then R12 re-expiry
        cfg_write(0, 0);
        cfg_write(1, 0);
        repeat (10) @(negedge clk);
        chk_state("R9 mode1 halt", 0, 1, 1, 0);
        do_poke();
        chk_state("R7 poke halted", 0, 0, 0, 0);
        repeat (4) @(negedge clk);
        chk_state("R12 one interval", 0, 1, 1, 0);

        // R11: length change mid-period applies from next reload
        cfg_write(0, 0);
        cfg_write(3, 2);
        repeat (10) @(negedge clk);
        cfg_write(3, 5);
        chk_state("R11 current period kept", 8 - 11 / DIV, 0, 0, 0);
        repeat (25) @(negedge clk);
        chk_state("R11 new length on reload", 20, 1, 1, 0);

        // R6: disable clears outputs and holds count, pokes included
        cfg_write(0, 7);
        chk_state("R6 disable", 28, 0, 0, 0);
        repeat (100) @(negedge clk);
        chk_state("R6 held off", 28, 0, 0, 0);
        chk("R6 no reset pulse", int'(rst_req_o), 0);
        do_poke();
        chk_state("R6 poke while off", 28, 0, 0, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule